// File: doc/BRIEF.md
# Serial EEPROM Host Write/Read Sequencer

This block is the host side of a link to a byte-addressable serial EEPROM. A local agent hands it a request made of a direction, a start address and a byte count; the block then runs every serial frame that the request needs on the four-wire serial bus and pulses a completion strobe, together with an error code, when it is finished. Write data is pulled from an input byte stream one byte at a time, and read data is pushed out on a byte stream with a one-cycle valid strobe.

For a write the block breaks the request into pieces that each stay inside one aligned page. Each piece gets its own enable frame, a status read that confirms the enable took effect, the data frame itself, and then status reads repeated until the memory reports it is no longer busy. A read is a single frame: the command, the address, then as many data bytes as were requested. The serial clock is a divided copy of the system clock, and chip select is held high for a minimum number of system cycles between frames.

Top module: `spi_eeprom_host`

## Requirements
- R1: Serial mode 0. SCK stays low whenever CS_N is high; each SCK half period lasts DIV system clocks; MOSI changes only while SCK is low; MISO is sampled at the rising SCK edge.
- R2: Every byte is sent most significant bit first; command frames that carry an address send it right after the command byte as ceil(ADDR_W/8) bytes, most significant byte first.
- R3: Every write data frame (command 02h) is preceded by a write-enable frame (command 06h, one byte) and then a status frame (command 05h plus one dummy byte), each in its own CS_N low period.
- R4: A write data frame carries at most PAGE data bytes and never crosses an address that is a multiple of PAGE; a longer or misaligned request is split into several such frames, the address advancing modulo 2^ADDR_W.
- R5: After each write data frame, status frames (05h) repeat while status bit 0 (busy) reads 1; the next command is issued only after a status frame in which bit 0 reads 0.
- R6: A read request produces one frame: command 03h, the address, then req_len bytes clocked consecutively; each received byte appears on rdata with a one-cycle rdata_valid, in address order.
- R7: If status bit 1 (write-enable latch) reads 0 in the status frame after a write enable, no write data frame is sent, no write data is taken, and the request ends with done and err_code = 1.
- R8: If POLL_MAX consecutive status polls after a write data frame all read busy, the request ends with done and err_code = 2 and no further frame is issued.
- R9: Between two frames CS_N stays high for at least CS_GAP system clocks.
- R10: A request with req_len = 0 is accepted and ends with done and err_code = 0 without any frame on the bus.
- R11: After reset CS_N is high, SCK is low, req_ready is high and done is low; req_ready is high only while no request is in progress.
- R12: Write data is taken from the input stream exactly once per data byte of a write data frame, in order, and only while CS_N is low; a successful write ends with done and err_code = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle (idle) |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Number of bytes |
| wdata_valid | input | 1 | Write byte available |
| wdata_ready | output | 1 | Write byte taken this cycle |
| wdata | input | 8 | Write byte |
| rdata_valid | output | 1 | Read byte strobe |
| rdata | output | 8 | Read byte |
| done | output | 1 | Request finished (one cycle) |
| err_code | output | 2 | 0 ok, 1 enable latch not set, 2 busy timeout; valid with done |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the memory |
| miso | input | 1 | Serial data from the memory |

## Verification
The assertions assume that a new request is offered only while req_ready is high and that req_write, req_addr and req_len stay put for the cycle it is taken; they also assume the memory changes MISO only while SCK is low. The bench offers requests from a task that waits for req_ready and drops req_valid one cycle later, and its memory model updates MISO only after it sees a falling SCK. Write bytes are presented through a queue that changes only just after a rising system clock, so a byte never changes in the cycle it is taken.

// File: rtl/spi_eeprom_host_pkg.sv
package spi_eeprom_host_pkg;

    typedef enum logic [2:0] {
        K_WREN,
        K_CHKWEL,
        K_WRITE,
        K_POLL,
        K_READ
    } frame_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GAP,
        S_LOAD,
        S_RUN,
        S_END
    } seq_state_e;

    localparam logic [7:0] CMD_WREN  = 8'h06;
    localparam logic [7:0] CMD_WRITE = 8'h02;
    localparam logic [7:0] CMD_READ  = 8'h03;
    localparam logic [7:0] CMD_RDSR  = 8'h05;

    localparam logic [1:0] ERR_NONE = 2'd0;
    localparam logic [1:0] ERR_WEL  = 2'd1;
    localparam logic [1:0] ERR_BUSY = 2'd2;

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sck,
    output logic       mosi
);

    localparam int CW = $clog2(DIV + 1);

    typedef struct packed {
        logic          active;
        logic          sck;
        logic [CW-1:0] cnt;
        logic [2:0]    bidx;
        logic [7:0]    tx;
        logic [7:0]    rx;
        logic          done;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.active) begin
            if (start) begin
                d.active = 1'b1;
                d.sck    = 1'b0;
                d.cnt    = '0;
                d.bidx   = '0;
                d.tx     = tx_byte;
            end
        end else if (q.cnt == CW'(DIV - 1)) begin
            d.cnt = '0;
            if (!q.sck) begin
                d.sck = 1'b1;
                d.rx  = {q.rx[6:0], miso};
            end else begin
                d.sck = 1'b0;
                if (q.bidx == 3'd7) begin
                    d.active = 1'b0;
                    d.done   = 1'b1;
                    d.tx     = '0;
                end else begin
                    d.bidx = q.bidx + 3'd1;
                    d.tx   = {q.tx[6:0], 1'b0};
                end
            end
        end else begin
            d.cnt = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.active;
    assign done    = q.done;
    assign rx_byte = q.rx;
    assign sck     = q.sck;
    assign mosi    = q.tx[7];

    // R1: data line holds still for the whole high phase of the clock
    p_mosi_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

endmodule

// File: rtl/spi_page_planner.sv
module spi_page_planner #(
    parameter int ADDR_W = 9,
    parameter int LEN_W  = 4,
    parameter int PAGE   = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  rem,
    output logic [LEN_W-1:0]  chunk
);

    localparam int PB = (PAGE > 1) ? $clog2(PAGE) : 0;

    logic [LEN_W:0] room;

    generate
        if (PB == 0) begin : g_unit_page
            assign room = (LEN_W + 1)'(1);
        end else begin : g_pow2_page
            logic [ADDR_W-1:0] offs;
            assign offs = addr & ADDR_W'(PAGE - 1);
            assign room = (LEN_W + 1)'(PAGE) - (LEN_W + 1)'(offs);
        end
    endgenerate

    assign chunk = ({1'b0, rem} < room) ? rem : room[LEN_W-1:0];

endmodule

// File: rtl/spi_eeprom_host.sv
module spi_eeprom_host
    import spi_eeprom_host_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int LEN_W    = 4,
    parameter int PAGE     = 8,
    parameter int DIV      = 4,
    parameter int CS_GAP   = 4,
    parameter int POLL_MAX = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              wdata_valid,
    output logic              wdata_ready,
    input  logic [7:0]        wdata,
    output logic              rdata_valid,
    output logic [7:0]        rdata,
    output logic              done,
    output logic [1:0]        err_code,
    output logic              sck,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);

    localparam int AB  = (ADDR_W + 7) / 8;
    localparam int AWB = AB * 8;
    localparam int IW  = $clog2(AB + (1 << LEN_W) + 2);
    localparam int GW  = $clog2(CS_GAP + 2);
    localparam int PW  = $clog2(POLL_MAX + 1);

    typedef struct packed {
        seq_state_e        st;
        frame_kind_e       kind;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
        logic [IW-1:0]     bidx;
        logic [GW-1:0]     gap;
        logic [PW-1:0]     polls;
        logic              cs_n;
        logic [1:0]        stat;
        logic              done;
        logic [1:0]        err;
        logic [7:0]        rdata;
        logic              rvalid;
    } seq_t;

    seq_t q, d;

    logic             sh_start, sh_busy, sh_done, sh_sck, sh_mosi;
    logic [7:0]       sh_rx, tx_byte;
    logic [LEN_W-1:0] chunk;
    logic             is_data;
    logic [IW-1:0]    last_idx;
    logic [AWB-1:0]   addr_word;

    spi_byte_shifter #(.DIV(DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (tx_byte),
        .miso    (miso),
        .busy    (sh_busy),
        .done    (sh_done),
        .rx_byte (sh_rx),
        .sck     (sh_sck),
        .mosi    (sh_mosi)
    );

    spi_page_planner #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE(PAGE)) u_plan (
        .addr  (q.addr),
        .rem   (q.rem),
        .chunk (chunk)
    );

    // byte content and frame length for the frame in progress
    always_comb begin
        int nbytes;
        int sh;
        addr_word = AWB'(q.addr);
        is_data   = (q.kind == K_WRITE) && (int'(q.bidx) > AB);
        tx_byte   = 8'h00;
        sh        = 0;
        if (q.bidx == '0) begin
            case (q.kind)
                K_WREN:  tx_byte = CMD_WREN;
                K_WRITE: tx_byte = CMD_WRITE;
                K_READ:  tx_byte = CMD_READ;
                default: tx_byte = CMD_RDSR;
            endcase
        end else if ((q.kind == K_WRITE || q.kind == K_READ) && int'(q.bidx) <= AB) begin
            sh      = 8 * (AB - int'(q.bidx));
            tx_byte = 8'(addr_word >> sh);
        end else if (is_data) begin
            tx_byte = wdata;
        end
        case (q.kind)
            K_WREN:  nbytes = 1;
            K_WRITE: nbytes = 1 + AB + int'(chunk);
            K_READ:  nbytes = 1 + AB + int'(q.rem);
            default: nbytes = 2;
        endcase
        last_idx = IW'(nbytes - 1);
    end

    assign sh_start    = (q.st == S_LOAD) && !sh_busy && (!is_data || wdata_valid);
    assign wdata_ready = (q.st == S_LOAD) && !sh_busy && is_data && wdata_valid;
    assign req_ready   = (q.st == S_IDLE);

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.err    = ERR_NONE;
        d.rvalid = 1'b0;

        if (!q.cs_n)                    d.gap = '0;
        else if (q.gap != GW'(CS_GAP))  d.gap = q.gap + GW'(1);

        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.addr  = req_addr;
                    d.rem   = req_len;
                    d.polls = '0;
                    if (req_len == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.kind = req_write ? K_WREN : K_READ;
                        d.st   = S_GAP;
                    end
                end
            end
            S_GAP: begin
                if (q.gap == GW'(CS_GAP)) begin
                    d.cs_n = 1'b0;
                    d.bidx = '0;
                    d.st   = S_LOAD;
                end
            end
            S_LOAD: begin
                if (sh_start) d.st = S_RUN;
            end
            S_RUN: begin
                if (sh_done) begin
                    if ((q.kind == K_CHKWEL || q.kind == K_POLL) && q.bidx == IW'(1))
                        d.stat = sh_rx[1:0];
                    if (q.kind == K_READ && int'(q.bidx) > AB) begin
                        d.rdata  = sh_rx;
                        d.rvalid = 1'b1;
                    end
                    if (q.bidx == last_idx) begin
                        d.cs_n = 1'b1;
                        d.st   = S_END;
                    end else begin
                        d.bidx = q.bidx + IW'(1);
                        d.st   = S_LOAD;
                    end
                end
            end
            S_END: begin
                d.st = S_GAP;
                case (q.kind)
                    K_WREN: d.kind = K_CHKWEL;
                    K_CHKWEL: begin
                        if (q.stat[1]) begin
                            d.kind = K_WRITE;
                        end else begin
                            d.done = 1'b1;
                            d.err  = ERR_WEL;
                            d.st   = S_IDLE;
                        end
                    end
                    K_WRITE: begin
                        d.kind  = K_POLL;
                        d.polls = '0;
                    end
                    K_POLL: begin
                        if (!q.stat[0]) begin
                            d.addr = q.addr + ADDR_W'(chunk);
                            d.rem  = q.rem - chunk;
                            if (q.rem == chunk) begin
                                d.done = 1'b1;
                                d.st   = S_IDLE;
                            end else begin
                                d.kind = K_WREN;
                            end
                        end else if (q.polls == PW'(POLL_MAX - 1)) begin
                            d.done = 1'b1;
                            d.err  = ERR_BUSY;
                            d.st   = S_IDLE;
                        end else begin
                            d.polls = q.polls + PW'(1);
                        end
                    end
                    default: begin
                        d.done = 1'b1;
                        d.st   = S_IDLE;
                    end
                endcase
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.kind <= K_WREN;
            q.cs_n <= 1'b1;
            q.gap  <= GW'(CS_GAP);
        end else begin
            q <= d;
        end
    end

    assign cs_n        = q.cs_n;
    assign sck         = sh_sck;
    assign mosi        = sh_mosi;
    assign done        = q.done;
    assign err_code    = q.err;
    assign rdata       = q.rdata;
    assign rdata_valid = q.rvalid;

    // independent count of chip-select high cycles for the spacing check
    logic [GW-1:0] hi_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          hi_run_q <= GW'(CS_GAP);
        else if (!cs_n)                      hi_run_q <= '0;
        else if (hi_run_q != GW'(CS_GAP))    hi_run_q <= hi_run_q + GW'(1);
    end

    p_sck_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    p_cs_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (hi_run_q == GW'(CS_GAP)));

    p_take_in_frame_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wdata_ready |-> !cs_n);

    p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code != ERR_NONE) |-> done);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cs_n && !sck));

    p_chunk_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_RUN && q.kind == K_WRITE) |-> (chunk != '0 && int'(chunk) <= PAGE));

endmodule

// File: tb/sim_spi_eeprom_host.sv
module sim_spi_eeprom_host;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 9;
    localparam int LEN_W      = 4;
    localparam int PAGE       = 8;
    localparam int DIV        = 2;
    localparam int CS_GAP     = 3;
    localparam int POLL_MAX   = 6;
    localparam int AB         = (ADDR_W + 7) / 8;
    localparam int MSZ        = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic wdata_valid = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic miso = 1'b0;
    logic req_ready, wdata_ready, rdata_valid, done, sck, cs_n, mosi;
    logic [7:0] rdata;
    logic [1:0] err_code;

    spi_eeprom_host #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE(PAGE), .DIV(DIV),
                      .CS_GAP(CS_GAP), .POLL_MAX(POLL_MAX)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
        .wdata_valid(wdata_valid), .wdata_ready(wdata_ready), .wdata(wdata),
        .rdata_valid(rdata_valid), .rdata(rdata), .done(done), .err_code(err_code),
        .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

    always #(CLK_PERIOD / 2) clk = ~clk;

    int total = 0;
    int bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // expected frames
    int    exp_op[$];
    int    exp_addr[$];
    int    exp_len[$];
    string exp_tag[$];
    byte   exp_wd[$];
    byte   exp_rd[$];
    byte   exp_mem[MSZ];

    // memory model state
    byte   mem[MSZ];
    bit    wel = 0;
    bit    wel_block = 0;
    int    busy_left = 0;
    int    busy_cfg = 0;
    int    frames_seen = 0;

    // write stream and observed outputs
    byte   wq[$];
    byte   got_rd[$];
    bit    done_seen = 0;
    int    done_err = 0;

    initial begin
        for (int i = 0; i < MSZ; i++) begin
            mem[i] = 0;
            exp_mem[i] = 0;
        end
    end

    task automatic end_frame(input byte fb[$]);
        int op, a, n;
        string tag;
        frames_seen++;
        if (fb.size() == 0) return;
        op = int'(fb[0]) & 255;
        if (exp_op.size() == 0) begin
            chk(0, "R3", "unexpected frame opcode", op, 0);
            return;
        end
        tag = exp_tag.pop_front();
        chk(op == exp_op[0], tag, "frame opcode", op, exp_op[0]);
        void'(exp_op.pop_front());
        a = 0;
        for (int i = 1; i <= AB && i < fb.size(); i++) a = (a << 8) | (int'(fb[i]) & 255);
        n = fb.size() - 1 - AB;
        if (op == 2 || op == 3) begin
            chk(a == exp_addr[0], "R2", "frame address", a, exp_addr[0]);
            chk(n == exp_len[0], tag, "frame data bytes", n, exp_len[0]);
        end
        void'(exp_addr.pop_front());
        void'(exp_len.pop_front());
        case (op)
            6: wel = !wel_block;
            5: if (busy_left > 0) busy_left--;
            2: begin
                for (int i = 0; i < n; i++) begin
                    byte e;
                    e = (exp_wd.size() != 0) ? exp_wd.pop_front() : 8'h00;
                    chk(fb[1 + AB + i] == e, "R12", "write byte", int'(fb[1 + AB + i]) & 255, int'(e) & 255);
                    if (wel) mem[(a + i) % MSZ] = fb[1 + AB + i];
                end
                if (wel) busy_left = busy_cfg;
                wel = 0;
            end
            default: ;
        endcase
    endtask

    // serial memory model and pin-level checks
    initial begin
        bit   prev_sck = 0, prev_cs = 1;
        byte  fb[$];
        byte  shin = 0, out_sh = 0, next_out = 0;
        int   sbit = 0, hi_run = 100, viol = 0;
        bit   mosi_hold = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                prev_sck = sck; prev_cs = cs_n;
                continue;
            end
            if (cs_n && sck) viol++;
            if (cs_n) hi_run++;
            if (!cs_n && prev_cs) begin
                chk(hi_run >= CS_GAP, "R9", "chip select high cycles", hi_run, CS_GAP);
                fb.delete(); sbit = 0; miso = 0; viol = 0;
            end
            if (!cs_n && sck && !prev_sck) begin
                mosi_hold = mosi;
                shin = {shin[6:0], mosi};
                sbit++;
                if (sbit == 8) begin
                    int k;
                    fb.push_back(shin);
                    sbit = 0;
                    next_out = 0;
                    if (fb[0] == 8'h05) next_out = {6'b0, wel, busy_left != 0};
                    else if (fb[0] == 8'h03 && fb.size() >= 1 + AB) begin
                        int a = 0;
                        for (int i = 1; i <= AB; i++) a = (a << 8) | (int'(fb[i]) & 255);
                        k = fb.size() - 1 - AB;
                        next_out = mem[(a + k) % MSZ];
                    end
                end
            end else if (!cs_n && sck && prev_sck) begin
                if (mosi != mosi_hold) viol++;
            end
            if (!cs_n && !sck && prev_sck) begin
                if (sbit == 0) out_sh = next_out;
                else out_sh = {out_sh[6:0], 1'b0};
                miso = out_sh[7];
            end
            if (cs_n && !prev_cs) begin
                hi_run = 1;
                chk(viol == 0, "R1", "clock/data phase violations in frame", viol, 0);
                end_frame(fb);
            end
            prev_sck = sck;
            prev_cs = cs_n;
        end
    end

    // output monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rdata_valid) got_rd.push_back(rdata);
            if (done) begin
                done_seen = 1;
                done_err = int'(err_code);
            end
        end
    end

    // write data source
    initial begin
        bit took;
        forever begin
            @(negedge clk);
            took = wdata_ready && wdata_valid;
            @(posedge clk);
            #1;
            if (took && wq.size() != 0) void'(wq.pop_front());
            wdata_valid = (wq.size() != 0);
            wdata = (wq.size() != 0) ? wq[0] : 8'h00;
        end
    end

    task automatic push_exp(input int op, input int a, input int n, input string tag);
        exp_op.push_back(op);
        exp_addr.push_back(a);
        exp_len.push_back(n);
        exp_tag.push_back(tag);
    endtask

    task automatic issue(input bit wr, input int a, input int n);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr;
        req_addr = ADDR_W'(a); req_len = LEN_W'(n);
        @(negedge clk);
        req_valid = 0;
        while (!done_seen) @(negedge clk);
        done_seen = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_write(input int a0, input int n, input int polls, input byte seed);
        int a = a0, left = n;
        busy_cfg = polls;
        for (int i = 0; i < n; i++) begin
            byte b = byte'(seed + 8'(i * 37));
            wq.push_back(b);
            exp_wd.push_back(b);
            exp_mem[(a0 + i) % MSZ] = b;
        end
        while (left > 0) begin
            int room = PAGE - (a % PAGE);
            int c = (left < room) ? left : room;
            push_exp(6, 0, 0, "R3");
            push_exp(5, 0, 0, "R3");
            push_exp(2, a, c, "R4");
            for (int p = 0; p <= polls; p++) push_exp(5, 0, 0, "R5");
            a = (a + c) % MSZ;
            left -= c;
        end
        issue(1, a0, n);
        chk(done_err == 0, "R12", "write error code", done_err, 0);
        chk(exp_op.size() == 0, "R5", "frames left unseen", exp_op.size(), 0);
        chk(wq.size() == 0, "R12", "write bytes left untaken", wq.size(), 0);
    endtask

    task automatic do_read(input int a, input int n);
        got_rd.delete();
        push_exp(3, a, n, "R6");
        issue(0, a, n);
        chk(got_rd.size() == n, "R6", "read byte count", got_rd.size(), n);
        for (int i = 0; i < n && i < got_rd.size(); i++)
            chk(got_rd[i] == exp_mem[(a + i) % MSZ], "R6", "read byte value",
                int'(got_rd[i]) & 255, int'(exp_mem[(a + i) % MSZ]) & 255);
        chk(done_err == 0, "R6", "read error code", done_err, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "ALL", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        chk(cs_n == 1, "R11", "reset cs_n", int'(cs_n), 1);
        chk(sck == 0, "R11", "reset sck", int'(sck), 0);
        chk(req_ready == 1, "R11", "reset req_ready", int'(req_ready), 1);
        chk(done == 0, "R11", "reset done", int'(done), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        do_write(16, 3, 2, 8'h11);         // inside one page
        do_write(9'h1FD, 8, 1, 8'h52);     // R4 split and address wrap
        do_write(9'h044, 8, 0, 8'h7C);     // R4 two halves
        do_write(9'h0F0, 12, 3, 8'hA3);    // R4 full page then rest
        do_read(9'h1FD, 10);               // R6 across the top of memory
        do_read(9'h044, 4);
        do_read(16, 3);

        // R10: empty request
        f0 = frames_seen;
        issue(0, 5, 0);
        chk(done_err == 0, "R10", "empty request error code", done_err, 0);
        chk(frames_seen == f0, "R10", "frames for empty request", frames_seen - f0, 0);

        // R7: write enable not latched
        wel_block = 1;
        for (int i = 0; i < 2; i++) wq.push_back(8'hEE);
        push_exp(6, 0, 0, "R7");
        push_exp(5, 0, 0, "R7");
        f0 = frames_seen;
        issue(1, 32, 2);
        chk(done_err == 1, "R7", "enable latch error code", done_err, 1);
        chk(frames_seen - f0 == 2, "R7", "frames for refused write", frames_seen - f0, 2);
        chk(wq.size() == 2, "R7", "write bytes taken", 2 - wq.size(), 0);
        wq.delete();
        wel_block = 0;

        // R8: memory stays busy
        busy_cfg = 100;
        wq.push_back(8'h5A); exp_wd.push_back(8'h5A); exp_mem[40] = 8'h5A;
        push_exp(6, 0, 0, "R8");
        push_exp(5, 0, 0, "R8");
        push_exp(2, 40, 1, "R8");
        for (int p = 0; p < POLL_MAX; p++) push_exp(5, 0, 0, "R8");
        issue(1, 40, 1);
        chk(done_err == 2, "R8", "busy timeout error code", done_err, 2);
        chk(exp_op.size() == 0, "R8", "frames left unseen", exp_op.size(), 0);
        busy_left = 0;
        repeat (10) @(negedge clk);
        chk(exp_op.size() == 0, "R8", "frames after timeout", exp_op.size(), 0);
        do_read(32, 12);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule